// File: doc/BRIEF.md
# Parallel NOR Flash Program Sequencer

This block connects a synchronous system to an asynchronous parallel NOR flash that is wired for byte-wide access. It accepts two kinds of request from the system side. A program request carries a 21-bit target address and one data byte. The block turns it into the four write bus cycles that the flash needs: three fixed unlock writes and then the write of the user byte. It then waits for a fixed, parameterised time before it reports completion. A read request needs no unlock. The block drives the address, pulls chip enable and output enable low, waits out the address access time and captures the byte.

Every flash pin is driven by a flop, and all pins are computed from the next state of the sequencer. Each write strobe is therefore clean: the address and data are set up while write enable is still high, held during the low pulse, and kept for a hold phase after the rising edge. The data bus leaves the block as three signals: a value, a drive enable and a return path. The pad ring builds the three-state buffer from them. A request is accepted only while the block is idle.

Top module: `nor_prog_seq`

## Requirements
- R1: The byte-mode select pin `fl_byte_n` is always 0. The flash reset pin `fl_rst_n` is 0 while `rst_n` is low and goes to 1 on the second rising clock edge after `rst_n` goes high.
- R2: A program operation makes exactly four write cycles, in this order: (0xAAA, 0xAA), then (0x555, 0x55), then (0xAAA, 0xA0), then (target address, user byte). Each pair is (address, data).
- R3: In every write cycle, `fl_addr` and `fl_dq_out` hold their values, and `fl_dq_oe` stays 1, from before `fl_we_n` falls until after it rises.
- R4: While `fl_we_n` is low, `fl_ce_n` is 0 and `fl_oe_n` is 1. Each write cycle lasts SETUP_CYC cycles with `fl_we_n` high, then PULSE_CYC cycles low, then HOLD_CYC cycles high. After the fourth write, the bus stays idle for PROG_WAIT_CYC cycles. `done` rises 4*(SETUP_CYC+PULSE_CYC+HOLD_CYC)+PROG_WAIT_CYC cycles after the accepting edge.
- R5: A read makes no write cycle. It drives the address with `fl_ce_n` low for SETUP_CYC cycles, then holds `fl_ce_n` and `fl_oe_n` low with `fl_we_n` high and `fl_dq_oe` at 0.
- R6: A read samples `fl_dq_in` only after `fl_oe_n` has been low for at least ACCESS_CYC full cycles. `done` rises SETUP_CYC+ACCESS_CYC+1 cycles after the accepting edge, and `rd_data` then holds the sampled byte until the next read completes.
- R7: While idle, and during reset, `fl_ce_n`, `fl_oe_n` and `fl_we_n` are 1 and `fl_dq_oe` is 0.
- R8: `busy` is 1 from the edge that accepts a request until the edge at which `done` rises. `done` is high for exactly one cycle, and only while `busy` is 0.
- R9: A request (`req_prog` or `req_read`) that is present while `busy` is 1 is ignored. It is neither executed nor held for later.
- R10: When `req_prog` and `req_read` are both 1 while the block is idle, the program operation is carried out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside the block |
| req_prog | input | 1 | Request to program one byte; sampled only while idle |
| req_read | input | 1 | Request to read one byte; sampled only while idle |
| req_addr | input | 21 | Target byte address for either request |
| req_wdata | input | 8 | Byte to be programmed |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse when an operation ends |
| rd_data | output | 8 | Byte captured by the last read |
| fl_addr | output | 21 | Flash address bus |
| fl_dq_out | output | 8 | Value for the flash data bus |
| fl_dq_oe | output | 1 | Drive enable for the data bus pads |
| fl_dq_in | input | 8 | Value returned from the flash data bus |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_rst_n | output | 1 | Flash reset, active low |
| fl_byte_n | output | 1 | Byte/word select, tied to byte mode |

## Verification
A wrong sequencer state or phase shows at the pins within the same cycle, because the pins are registered from the next state. The possible symptoms are an unlock write out of order, a write strobe whose address or data moves while write enable is low, output enable low during a write, or a driven data bus during a read. A phase counter that is off by one does not show as a bad pin value. It shows as a `done` that arrives one cycle early or late against the exact cycle counts of R4 and R6. A read captured too early returns a visibly invalid byte from the flash model. A request that leaked in while busy shows as extra write cycles, or as `busy` rising again without a fresh request.

// File: rtl/norseq_pkg.sv
package norseq_pkg;

  typedef enum logic [3:0] {
    S_IDLE   = 4'd0,
    S_UNLK1  = 4'd1,
    S_UNLK2  = 4'd2,
    S_CMD    = 4'd3,
    S_PROG   = 4'd4,
    S_WAIT   = 4'd5,
    S_RSETUP = 4'd6,
    S_RWAIT  = 4'd7,
    S_CAPT   = 4'd8
  } seq_state_t;

  typedef enum logic [1:0] {
    PH_SETUP = 2'd0,
    PH_LOW   = 2'd1,
    PH_HOLD  = 2'd2
  } wr_phase_t;

  // unlock key words, byte mode
  localparam logic [11:0] KEY_ADDR_HI = 12'hAAA;
  localparam logic [11:0] KEY_ADDR_LO = 12'h555;
  localparam logic [7:0]  KEY_BYTE_1  = 8'hAA;
  localparam logic [7:0]  KEY_BYTE_2  = 8'h55;
  localparam logic [7:0]  OPC_PROGRAM = 8'hA0;

  function automatic int max_of5(input int a, input int b, input int c,
                                 input int d, input int e);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    if (e > m) m = e;
    return m;
  endfunction

  function automatic logic is_write_state(input seq_state_t s);
    return (s == S_UNLK1) || (s == S_UNLK2) || (s == S_CMD) || (s == S_PROG);
  endfunction

endpackage

// File: rtl/nor_rst_sync.sv
module nor_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign srst_n = out_q;

endmodule

// File: rtl/nor_phase_timer.sv
module nor_phase_timer #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  output logic [CW-1:0] cnt
);

  logic [CW-1:0] cnt_d;

  always_comb begin
    if (clr) cnt_d = '0;
    else     cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

endmodule

// File: rtl/nor_seq_fsm.sv
module nor_seq_fsm
  import norseq_pkg::*;
#(
  parameter int SETUP_CYC     = 2,
  parameter int PULSE_CYC     = 3,
  parameter int HOLD_CYC      = 2,
  parameter int ACCESS_CYC    = 10,
  parameter int PROG_WAIT_CYC = 20,
  parameter int CW            = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_prog,
  input  logic          req_read,
  input  logic [CW-1:0] cnt,
  output seq_state_t    state_q,
  output seq_state_t    state_d,
  output wr_phase_t     phase_q,
  output wr_phase_t     phase_d,
  output logic          advance
);

  int        limit;
  logic      phase_end;

  // length of the current phase in cycles
  always_comb begin
    limit = 1;
    if (is_write_state(state_q)) begin
      case (phase_q)
        PH_SETUP: limit = SETUP_CYC;
        PH_LOW:   limit = PULSE_CYC;
        default:  limit = HOLD_CYC;
      endcase
    end else begin
      case (state_q)
        S_WAIT:   limit = PROG_WAIT_CYC;
        S_RSETUP: limit = SETUP_CYC;
        S_RWAIT:  limit = ACCESS_CYC;
        default:  limit = 1;
      endcase
    end
  end

  assign phase_end = (cnt == CW'(limit - 1));

  function automatic seq_state_t after_write(input seq_state_t s);
    case (s)
      S_UNLK1: return S_UNLK2;
      S_UNLK2: return S_CMD;
      S_CMD:   return S_PROG;
      default: return S_WAIT;
    endcase
  endfunction

  // next-state process
  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    advance = 1'b0;
    case (state_q)
      S_IDLE: begin
        advance = 1'b1;
        phase_d = PH_SETUP;
        if (req_prog)      state_d = S_UNLK1;
        else if (req_read) state_d = S_RSETUP;
      end
      S_UNLK1, S_UNLK2, S_CMD, S_PROG: begin
        if (phase_end) begin
          advance = 1'b1;
          case (phase_q)
            PH_SETUP: phase_d = PH_LOW;
            PH_LOW:   phase_d = PH_HOLD;
            default: begin
              phase_d = PH_SETUP;
              state_d = after_write(state_q);
            end
          endcase
        end
      end
      S_WAIT: begin
        if (phase_end) begin
          advance = 1'b1;
          state_d = S_IDLE;
        end
      end
      S_RSETUP: begin
        if (phase_end) begin
          advance = 1'b1;
          state_d = S_RWAIT;
        end
      end
      S_RWAIT: begin
        if (phase_end) begin
          advance = 1'b1;
          state_d = S_CAPT;
        end
      end
      S_CAPT: begin
        advance = 1'b1;
        state_d = S_IDLE;
      end
      default: begin
        advance = 1'b1;
        state_d = S_IDLE;
        phase_d = PH_SETUP;
      end
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      phase_q <= PH_SETUP;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
    end
  end

endmodule

// File: rtl/nor_bus_drive.sv
module nor_bus_drive
  import norseq_pkg::*;
#(
  parameter int AW = 21,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  seq_state_t    state_q,
  input  seq_state_t    state_d,
  input  wr_phase_t     phase_d,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] fl_dq_in,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_dq_out,
  output logic          fl_dq_oe,
  output logic          fl_ce_n,
  output logic          fl_we_n,
  output logic          fl_oe_n,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rd_data
);

  logic [AW-1:0] tgt_addr_q;
  logic [DW-1:0] tgt_data_q;
  logic          accept;
  logic          capture_en;
  logic [AW-1:0] op_addr;

  logic [AW-1:0] addr_n;
  logic [DW-1:0] dq_n;
  logic          oe_drv_n;
  logic          ce_n_n;
  logic          we_n_n;
  logic          oe_n_n;

  assign accept     = (state_q == S_IDLE) && (state_d != S_IDLE);
  assign capture_en = (state_q == S_CAPT);
  assign op_addr    = accept ? req_addr : tgt_addr_q;

  // request operands, clock-enabled on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_addr_q <= '0;
      tgt_data_q <= '0;
    end else if (accept) begin
      tgt_addr_q <= req_addr;
      tgt_data_q <= req_wdata;
    end
  end

  // pin values for the coming cycle
  always_comb begin
    addr_n   = '0;
    dq_n     = '0;
    oe_drv_n = 1'b0;
    ce_n_n   = 1'b1;
    we_n_n   = 1'b1;
    oe_n_n   = 1'b1;
    case (state_d)
      S_UNLK1: begin
        addr_n = AW'(KEY_ADDR_HI);
        dq_n   = DW'(KEY_BYTE_1);
      end
      S_UNLK2: begin
        addr_n = AW'(KEY_ADDR_LO);
        dq_n   = DW'(KEY_BYTE_2);
      end
      S_CMD: begin
        addr_n = AW'(KEY_ADDR_HI);
        dq_n   = DW'(OPC_PROGRAM);
      end
      S_PROG: begin
        addr_n = tgt_addr_q;
        dq_n   = tgt_data_q;
      end
      S_RSETUP: begin
        addr_n = op_addr;
        ce_n_n = 1'b0;
      end
      S_RWAIT, S_CAPT: begin
        addr_n = op_addr;
        ce_n_n = 1'b0;
        oe_n_n = 1'b0;
      end
      default: ;
    endcase
    if (is_write_state(state_d)) begin
      oe_drv_n = 1'b1;
      ce_n_n   = 1'b0;
      we_n_n   = (phase_d != PH_LOW);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fl_addr   <= '0;
      fl_dq_out <= '0;
      fl_dq_oe  <= 1'b0;
      fl_ce_n   <= 1'b1;
      fl_we_n   <= 1'b1;
      fl_oe_n   <= 1'b1;
      busy      <= 1'b0;
      done      <= 1'b0;
    end else begin
      fl_addr   <= addr_n;
      fl_dq_out <= dq_n;
      fl_dq_oe  <= oe_drv_n;
      fl_ce_n   <= ce_n_n;
      fl_we_n   <= we_n_n;
      fl_oe_n   <= oe_n_n;
      busy      <= (state_d != S_IDLE);
      done      <= (state_d == S_IDLE) && (state_q != S_IDLE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rd_data <= '0;
    else if (capture_en) rd_data <= fl_dq_in;
  end

endmodule

// File: rtl/nor_prog_seq.sv
module nor_prog_seq
  import norseq_pkg::*;
#(
  parameter int AW            = 21,
  parameter int DW            = 8,
  parameter int SETUP_CYC     = 2,
  parameter int PULSE_CYC     = 3,
  parameter int HOLD_CYC      = 2,
  parameter int ACCESS_CYC    = 10,
  parameter int PROG_WAIT_CYC = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_prog,
  input  logic          req_read,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_dq_out,
  output logic          fl_dq_oe,
  input  logic [DW-1:0] fl_dq_in,
  output logic          fl_ce_n,
  output logic          fl_we_n,
  output logic          fl_oe_n,
  output logic          fl_rst_n,
  output logic          fl_byte_n
);

  localparam int MAX_CYC = max_of5(SETUP_CYC, PULSE_CYC, HOLD_CYC,
                                   ACCESS_CYC, PROG_WAIT_CYC);
  localparam int CW      = $clog2(MAX_CYC + 1);

  logic          srst_n;
  logic          advance;
  logic [CW-1:0] cnt;
  seq_state_t    state_q;
  seq_state_t    state_d;
  wr_phase_t     phase_q;
  wr_phase_t     phase_d;

  nor_rst_sync i_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  nor_phase_timer #(.CW(CW)) i_timer (
    .clk   (clk),
    .rst_n (srst_n),
    .clr   (advance),
    .cnt   (cnt)
  );

  nor_seq_fsm #(
    .SETUP_CYC     (SETUP_CYC),
    .PULSE_CYC     (PULSE_CYC),
    .HOLD_CYC      (HOLD_CYC),
    .ACCESS_CYC    (ACCESS_CYC),
    .PROG_WAIT_CYC (PROG_WAIT_CYC),
    .CW            (CW)
  ) i_fsm (
    .clk      (clk),
    .rst_n    (srst_n),
    .req_prog (req_prog),
    .req_read (req_read),
    .cnt      (cnt),
    .state_q  (state_q),
    .state_d  (state_d),
    .phase_q  (phase_q),
    .phase_d  (phase_d),
    .advance  (advance)
  );

  nor_bus_drive #(.AW(AW), .DW(DW)) i_drive (
    .clk       (clk),
    .rst_n     (srst_n),
    .state_q   (state_q),
    .state_d   (state_d),
    .phase_d   (phase_d),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .fl_dq_in  (fl_dq_in),
    .fl_addr   (fl_addr),
    .fl_dq_out (fl_dq_out),
    .fl_dq_oe  (fl_dq_oe),
    .fl_ce_n   (fl_ce_n),
    .fl_we_n   (fl_we_n),
    .fl_oe_n   (fl_oe_n),
    .busy      (busy),
    .done      (done),
    .rd_data   (rd_data)
  );

  assign fl_rst_n  = srst_n;
  assign fl_byte_n = 1'b0;

endmodule

// File: rtl/nor_prog_seq_chk.sv
module nor_prog_seq_chk #(
  parameter int AW = 21,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          fl_rst_n,
  input logic          busy,
  input logic          done,
  input logic [AW-1:0] fl_addr,
  input logic [DW-1:0] fl_dq_out,
  input logic          fl_dq_oe,
  input logic          fl_ce_n,
  input logic          fl_we_n,
  input logic          fl_oe_n
);

  logic       we_prev;
  logic       busy_prev;
  logic [2:0] wr_cnt;

  // write strobes seen since the operation began
  always_ff @(posedge clk or negedge fl_rst_n) begin
    if (!fl_rst_n) begin
      we_prev   <= 1'b1;
      busy_prev <= 1'b0;
      wr_cnt    <= '0;
    end else begin
      we_prev   <= fl_we_n;
      busy_prev <= busy;
      if (busy && !busy_prev)       wr_cnt <= '0;
      else if (we_prev && !fl_we_n) wr_cnt <= wr_cnt + 1'b1;
    end
  end

  p_addr_setup_r3: assert property (@(posedge clk) disable iff (!fl_rst_n)
    $fell(fl_we_n) |-> $stable(fl_addr) && $stable(fl_dq_out) && fl_dq_oe);

  p_data_hold_r3: assert property (@(posedge clk) disable iff (!fl_rst_n)
    $rose(fl_we_n) |-> $stable(fl_addr) && $stable(fl_dq_out) && fl_dq_oe);

  p_we_strobes_r4: assert property (@(posedge clk) disable iff (!fl_rst_n)
    !fl_we_n |-> !fl_ce_n && fl_oe_n);

  p_read_release_r5: assert property (@(posedge clk) disable iff (!fl_rst_n)
    !fl_oe_n |-> !fl_dq_oe && fl_we_n && !fl_ce_n);

  p_read_no_write_r5: assert property (@(posedge clk) disable iff (!fl_rst_n)
    !fl_oe_n |-> wr_cnt == 3'd0);

  p_write_count_r2: assert property (@(posedge clk) disable iff (!fl_rst_n)
    done |-> (wr_cnt == 3'd0) || (wr_cnt == 3'd4));

  p_idle_bus_r7: assert property (@(posedge clk) disable iff (!fl_rst_n)
    !busy |-> fl_ce_n && fl_oe_n && fl_we_n && !fl_dq_oe);

  p_done_end_r8: assert property (@(posedge clk) disable iff (!fl_rst_n)
    done |-> !busy && $past(busy));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!fl_rst_n)
    done |=> !done);

endmodule

bind nor_prog_seq nor_prog_seq_chk #(.AW(AW), .DW(DW)) i_chk (
  .clk       (clk),
  .fl_rst_n  (fl_rst_n),
  .busy      (busy),
  .done      (done),
  .fl_addr   (fl_addr),
  .fl_dq_out (fl_dq_out),
  .fl_dq_oe  (fl_dq_oe),
  .fl_ce_n   (fl_ce_n),
  .fl_we_n   (fl_we_n),
  .fl_oe_n   (fl_oe_n)
);

// File: tb/test_nor_prog_seq.sv
module test_nor_prog_seq;

  localparam int AW = 21;
  localparam int DW = 8;
  localparam int S  = 2;
  localparam int P  = 3;
  localparam int H  = 2;
  localparam int A  = 10;
  localparam int W  = 20;
  localparam int T_PROG = 4 * (S + P + H) + W;
  localparam int T_READ = S + A + 1;

  logic          clk;
  logic          rst_n;
  logic          req_prog;
  logic          req_read;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          busy;
  logic          done;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_dq_out;
  logic          fl_dq_oe;
  logic [DW-1:0] fl_dq_in;
  logic          fl_ce_n;
  logic          fl_we_n;
  logic          fl_oe_n;
  logic          fl_rst_n;
  logic          fl_byte_n;

  int checks;
  int errors;
  bit finished;

  nor_prog_seq #(
    .AW(AW), .DW(DW), .SETUP_CYC(S), .PULSE_CYC(P), .HOLD_CYC(H),
    .ACCESS_CYC(A), .PROG_WAIT_CYC(W)
  ) i_nor_prog_seq (
    .clk(clk), .rst_n(rst_n), .req_prog(req_prog), .req_read(req_read),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rd_data(rd_data), .fl_addr(fl_addr), .fl_dq_out(fl_dq_out),
    .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in), .fl_ce_n(fl_ce_n),
    .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n), .fl_rst_n(fl_rst_n),
    .fl_byte_n(fl_byte_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // ---------------- behavioural flash model ----------------
  logic [7:0]    mem [64];
  logic [AW-1:0] log_a [64];
  logic [7:0]    log_d [64];
  int            log_n;
  int            viol;
  logic          we_q;
  logic [AW-1:0] lat_a;
  int            acc;
  int            ustep;

  always @(posedge clk) begin
    we_q <= fl_we_n;
    if (!fl_rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= 8'hFF;
      acc   <= 0;
      ustep <= 0;
    end else begin
      if (!fl_ce_n && !fl_oe_n) acc <= acc + 1;
      else                      acc <= 0;
      if (!fl_oe_n && fl_dq_oe) viol <= viol + 1;
      if (we_q && !fl_we_n) begin
        lat_a <= fl_addr;
        if (fl_ce_n || !fl_oe_n || !fl_dq_oe) viol <= viol + 1;
      end
      if (!we_q && fl_we_n) begin
        if (fl_ce_n || !fl_oe_n || !fl_dq_oe) viol <= viol + 1;
        log_a[log_n[5:0]] <= lat_a;
        log_d[log_n[5:0]] <= fl_dq_out;
        log_n <= log_n + 1;
        case (ustep)
          0: ustep <= (lat_a == 21'hAAA && fl_dq_out == 8'hAA) ? 1 : 0;
          1: ustep <= (lat_a == 21'h555 && fl_dq_out == 8'h55) ? 2 : 0;
          2: ustep <= (lat_a == 21'hAAA && fl_dq_out == 8'hA0) ? 3 : 0;
          default: begin
            mem[lat_a[5:0]] <= mem[lat_a[5:0]] & fl_dq_out;
            ustep <= 0;
          end
        endcase
      end
    end
  end

  assign fl_dq_in = (!fl_ce_n && !fl_oe_n && acc >= A) ? mem[fl_addr[5:0]] : 8'hEE;

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 100000, 0);
    finish_run();
  end

  // issue a request and count negedges until done is seen
  task automatic issue(input bit prog, input bit rd, input logic [AW-1:0] a,
                       input logic [7:0] d, output int n);
    @(negedge clk);
    req_prog  = prog;
    req_read  = rd;
    req_addr  = a;
    req_wdata = d;
    @(negedge clk);
    req_prog = 1'b0;
    req_read = 1'b0;
    n = 1;
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    rst_n = 1'b0; req_prog = 1'b0; req_read = 1'b0;
    req_addr = '0; req_wdata = '0;
    viol = 0; log_n = 0;
    repeat (4) @(negedge clk);
    check(fl_rst_n == 1'b0, "R1 flash reset low in reset", 32'(fl_rst_n), 0);
    check(fl_byte_n == 1'b0, "R1 byte mode pin", 32'(fl_byte_n), 0);
    check({fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe} == 4'b1110,
          "R7 idle strobes in reset", 32'({fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe}), 32'hE);
    check({busy, done} == 2'b00, "R8 flags in reset", 32'({busy, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(fl_rst_n == 1'b0, "R1 release not before second edge", 32'(fl_rst_n), 0);
    @(negedge clk);
    check(fl_rst_n == 1'b1, "R1 release at second edge", 32'(fl_rst_n), 1);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_program(input logic [AW-1:0] a, input logic [7:0] d, input string tag);
    int n, base, v0;
    base = log_n; v0 = viol;
    issue(1'b1, 1'b0, a, d, n);
    check(n == T_PROG + 1, {"R4 program duration ", tag}, 32'(n), 32'(T_PROG + 1));
    check(log_n - base == 4, {"R2 write count ", tag}, 32'(log_n - base), 4);
    check(log_a[base[5:0]] == 21'hAAA && log_d[base[5:0]] == 8'hAA,
          {"R2 first unlock ", tag}, {log_a[base[5:0]][23:0], log_d[base[5:0]]}, 32'hAAAAA);
    check(log_a[6'(base + 1)] == 21'h555 && log_d[6'(base + 1)] == 8'h55,
          {"R2 second unlock ", tag}, {log_a[6'(base + 1)][23:0], log_d[6'(base + 1)]}, 32'h55555);
    check(log_a[6'(base + 2)] == 21'hAAA && log_d[6'(base + 2)] == 8'hA0,
          {"R2 program command ", tag}, {log_a[6'(base + 2)][23:0], log_d[6'(base + 2)]}, 32'hAAAA0);
    check(log_a[6'(base + 3)] == a && log_d[6'(base + 3)] == d,
          {"R2 target write ", tag}, {log_a[6'(base + 3)][23:0], log_d[6'(base + 3)]}, {3'b0, a, d});
    check(viol == v0, {"R3 strobe protocol ", tag}, 32'(viol - v0), 0);
    check(busy == 1'b0, {"R8 busy low at done ", tag}, 32'(busy), 0);
    @(negedge clk);
    check(done == 1'b0, {"R8 done single cycle ", tag}, 32'(done), 0);
  endtask

  task automatic t_read(input logic [AW-1:0] a, input logic [7:0] exp, input string tag);
    int n, base, v0;
    base = log_n; v0 = viol;
    issue(1'b0, 1'b1, a, 8'h00, n);
    check(n == T_READ + 1, {"R6 read duration ", tag}, 32'(n), 32'(T_READ + 1));
    check(rd_data == exp, {"R6 read data ", tag}, 32'(rd_data), 32'(exp));
    check(log_n == base, {"R5 no write during read ", tag}, 32'(log_n - base), 0);
    check(viol == v0, {"R5 bus released ", tag}, 32'(viol - v0), 0);
    @(negedge clk);
    check(done == 1'b0 && rd_data == exp, {"R8 done pulse, data kept ", tag},
          32'({done, rd_data}), 32'(exp));
  endtask

  task automatic t_ignore();
    int n, base;
    base = log_n;
    @(negedge clk);
    req_prog = 1'b1; req_addr = 21'h000010; req_wdata = 8'h3C;
    @(negedge clk);
    req_prog = 1'b0;
    repeat (3) @(negedge clk);
    check(busy == 1'b1, "R8 busy during program", 32'(busy), 1);
    req_prog = 1'b1; req_read = 1'b1; req_addr = 21'h000011; req_wdata = 8'h00;
    repeat (5) @(negedge clk);
    req_prog = 1'b0; req_read = 1'b0;
    n = 0;
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
    end
    check(log_n - base == 4, "R9 stray requests add no writes", 32'(log_n - base), 4);
    check(log_a[6'(base + 3)] == 21'h10, "R9 target unchanged", 32'(log_a[6'(base + 3)]), 32'h10);
    repeat (2) @(negedge clk);
    check(busy == 1'b0, "R9 nothing queued", 32'(busy), 0);
    t_read(21'h000011, 8'hFF, "untouched byte");
    t_read(21'h000010, 8'h3C, "kept byte");
  endtask

  task automatic t_priority();
    int n, base;
    base = log_n;
    issue(1'b1, 1'b1, 21'h000020, 8'h81, n);
    check(n == T_PROG + 1, "R10 program chosen (duration)", 32'(n), 32'(T_PROG + 1));
    check(log_n - base == 4, "R10 program chosen (writes)", 32'(log_n - base), 4);
    t_read(21'h000020, 8'h81, "priority byte");
  endtask

  initial begin
    checks = 0; errors = 0; finished = 1'b0;
    t_reset();
    t_read(21'h000005, 8'hFF, "erased");
    t_program(21'h000003, 8'h5A, "low address");
    t_read(21'h000003, 8'h5A, "low address");
    t_program(21'h1FFFFF, 8'h00, "top address");
    t_read(21'h1FFFFF, 8'h00, "top address");
    t_ignore();
    t_priority();
    finish_run();
  end

endmodule